// File: doc/BRIEF.md
# Variable-Latency Execute Stage

This block is the execute slot of a single-issue, in-order pipeline that models timing and occupancy only. Decode presents one operation at a time as a valid flag, a five-bit operation class and an opaque tag. The stage keeps that operation for as many cycles as its class requires. It then hands the tag to the memory-side latch with a valid flag. Operand values, results and memory traffic are not part of this block.

A down-counter drives the stage. When an operation arrives at an idle stage, the counter is loaded with the class latency minus one. Each later cycle with a valid input counts it down by one. The output latch receives the operation only in the cycle in which the updated count is zero; every other cycle sends a bubble. While the count is nonzero the `busy` output is high, and decode and fetch must hold their latches, so the same class and tag stay on the inputs until the operation leaves.

Top module: `vlx_exec_stage`

## Requirements
- R1: Class codes 0 to 9 and code 23 take one cycle: the tag appears with `out_valid` high at the first clock edge after it is presented, and `busy` stays low.
- R2: Class codes 10 to 18 take two cycles: `busy` is high for exactly one cycle, and `out_valid` rises at the second edge after presentation.
- R3: Class codes 19 to 21 take four cycles: `busy` is high for exactly three cycles, and the output becomes valid at the fourth edge.
- R4: Class code 22 takes sixteen cycles: `busy` is high for exactly fifteen cycles, and the output becomes valid at the sixteenth edge.
- R5: While `busy` is high, `out_valid` is low. When the operation completes, `out_tag` equals the tag that was held on the input.
- R6: An invalid input while the stage is idle produces an invalid output at the next edge and leaves `busy` low.
- R7: An invalid input while the counter is nonzero leaves the count unchanged. `busy` stays high, and completion is delayed by the same number of cycles.
- R8: Unassigned class codes 24 to 31 are treated as latency one.
- R9: A synchronous active-high reset clears the count and `out_valid` at the next edge, including in the middle of a multi-cycle operation.
- R10: A new operation presented in the cycle right after a completion is accepted at once, so operations run back to back without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decode latch holds an operation |
| in_class | input | 5 | Operation class code |
| in_tag | input | TAG_W | Opaque operation tag |
| out_valid | output | 1 | Output latch holds a completed operation |
| out_tag | output | TAG_W | Tag of the completed operation |
| busy | output | 1 | Count nonzero; upstream stages must hold |

## Verification
Every one of the 32 class codes is issued back to back. This separates the four latency groups by the exact count of `busy` cycles, and it separates the unassigned codes from the sixteen-cycle code. Idle gaps with the valid flag low show whether bubbles pass straight through from an empty stage. Gaps inserted in the middle of a count show whether an invalid input freezes the counter or wrongly advances it. A reset applied in the middle of the long divide shows whether the counter is cleared rather than left to run out.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

    localparam int unsigned CLASS_W       = 5;
    localparam int unsigned TWO_FIRST     = 10;
    localparam int unsigned FOUR_FIRST    = 19;
    localparam int unsigned SIXTEEN_CODE  = 22;
    localparam int unsigned FP_BRANCH     = 23;

    function automatic int unsigned lat_of(input logic [CLASS_W-1:0] cls);
        int unsigned c;
        c = int'(cls);
        if (c < TWO_FIRST)          return 1;
        else if (c < FOUR_FIRST)    return 2;
        else if (c < SIXTEEN_CODE)  return 4;
        else if (c == SIXTEEN_CODE) return 16;
        else                        return 1;
    endfunction

endpackage

// File: rtl/vlx_lat_lookup.sv
module vlx_lat_lookup #(
    parameter int unsigned CNT_W = 4
) (
    input  logic [vlx_pkg::CLASS_W-1:0] cls,
    output logic [CNT_W-1:0]            reload
);
    always_comb begin
        reload = CNT_W'(vlx_pkg::lat_of(cls) - 1);
    end
endmodule

// File: rtl/vlx_countdown.sv
module vlx_countdown #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic             expire,
    output logic             busy
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (step) begin
            if (st_q.cnt == '0) st_d.cnt = reload;
            else                st_d.cnt = st_q.cnt - 1'b1;
            expire = (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);
endmodule

// File: rtl/vlx_exec_stage.sv
module vlx_exec_stage #(
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned MAX_LAT = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [vlx_pkg::CLASS_W-1:0] in_class,
    input  logic [TAG_W-1:0]            in_tag,
    output logic                        out_valid,
    output logic [TAG_W-1:0]            out_tag,
    output logic                        busy
);
    localparam int unsigned CNT_W = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } olat_t;

    olat_t            ol_d, ol_q;
    logic [CNT_W-1:0] reload;
    logic             expire;

    vlx_lat_lookup #(.CNT_W(CNT_W)) u_lut (
        .cls    (in_class),
        .reload (reload)
    );

    vlx_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .reload (reload),
        .expire (expire),
        .busy   (busy)
    );

    always_comb begin
        ol_d = '0;
        if (!in_valid) begin
            ol_d.tag = in_tag;
        end else if (expire) begin
            ol_d.vld = 1'b1;
            ol_d.tag = in_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ol_q <= '0;
        else     ol_q <= ol_d;
    end

    assign out_valid = ol_q.vld;
    assign out_tag   = ol_q.tag;
endmodule

// File: rtl/vlx_exec_stage_chk.sv
module vlx_exec_stage_chk #(
    parameter int unsigned TAG_W = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic [vlx_pkg::CLASS_W-1:0] in_class,
    input logic [TAG_W-1:0]            in_tag,
    input logic                        out_valid,
    input logic [TAG_W-1:0]            out_tag,
    input logic                        busy
);
    AST_SHORT_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && vlx_pkg::lat_of(in_class) == 1)
        |=> (out_valid && !busy && out_tag == $past(in_tag)));                  // R1
    AST_LONG_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && in_class == 5'd22) |=> (busy && !out_valid));     // R4
    AST_BUSY_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !out_valid);                                                   // R5
    AST_IDLE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !busy) |=> (!out_valid && !busy));                        // R6
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && busy) |=> (busy && !out_valid));                          // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !busy));                                         // R9
endmodule

bind vlx_exec_stage vlx_exec_stage_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .busy      (busy)
);

// File: tb/vlx_exec_stage_test.sv
module vlx_exec_stage_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [4:0] in_class = '0;
    logic [7:0] in_tag = '0;
    logic       out_valid;
    logic [7:0] out_tag;
    logic       busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlx_exec_stage #(.TAG_W(8), .MAX_LAT(16)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_tag(in_tag), .out_valid(out_valid), .out_tag(out_tag), .busy(busy)
    );

    function automatic int ref_lat(input int code);
        if (code >= 10 && code <= 18) return 2;   // R2
        if (code >= 19 && code <= 21) return 4;   // R3
        if (code == 22)               return 16;  // R4
        return 1;                                 // R1, R8
    endfunction

    function automatic string lat_req(input int code);
        if (code >= 24) return "R8";
        case (ref_lat(code))
            2:       return "R2";
            4:       return "R3";
            16:      return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_tag   = 8'(i * 37 + 5);
            tick();
            chk(req, "idle out_valid", int'(out_valid), 0);
            chk(req, "idle busy", int'(busy), 0);
        end
    endtask

    task automatic issue(input int code, input int tag, input int pause_at, input int pause_len);
        int lat;
        string rq;
        lat = ref_lat(code);
        rq  = lat_req(code);
        in_class = 5'(code);
        in_tag   = 8'(tag);
        for (int s = 1; s <= lat; s++) begin
            if (pause_at > 0 && s == pause_at + 1) begin
                for (int p = 0; p < pause_len; p++) begin
                    in_valid = 1'b0;
                    tick();
                    chk("R7", "pause busy", int'(busy), 1);
                    chk("R7", "pause out_valid", int'(out_valid), 0);
                end
            end
            in_valid = 1'b1;
            tick();
            chk(rq, "busy", int'(busy), (s < lat) ? 1 : 0);
            chk((s < lat) ? "R5" : rq, "out_valid", int'(out_valid), (s == lat) ? 1 : 0);
            if (s == lat) chk("R5", "out_tag", int'(out_tag), tag);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "reset out_valid", int'(out_valid), 0);
        chk("R9", "reset busy", int'(busy), 0);
        rst = 1'b0;
        idle(3, "R6");
        // R10: every code issued back to back with no gap
        for (int c = 0; c < 32; c++) issue(c, 8'h40 + c, 0, 0);
        idle(2, "R6");
        issue(22, 8'hA5, 5, 3);   // R7 long pause mid-divide
        issue(19, 8'h5A, 1, 2);   // R7 short pause
        issue(7,  8'h11, 0, 0);   // R10 after a paused op
        idle(2, "R6");
        // R9: reset in the middle of a sixteen-cycle operation
        in_class = 5'd22;
        in_tag   = 8'hC3;
        in_valid = 1'b1;
        repeat (4) tick();
        chk("R9", "busy before reset", int'(busy), 1);
        rst = 1'b1;
        tick();
        chk("R9", "mid reset busy", int'(busy), 0);
        chk("R9", "mid reset out_valid", int'(out_valid), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        idle(2, "R9");
        issue(12, 8'h77, 0, 0);
        issue(24, 8'h78, 0, 0);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end
endmodule